// File: doc/BRIEF.md
# Thermal Alarm Qualifier

This block decides the state of an overtemperature alarm pin. Each time a temperature conversion finishes, it takes the signed result and compares it with two programmable signed limits. One limit is the upper trip point. The other is the lower release point. A fault filter must see a programmable number of consecutive qualifying conversions before the alarm changes state. The alarm is then driven with a selectable active level. The pad logic outside this block does the open-drain conversion.

There are two alarm modes. In thermostat mode the alarm follows the temperature with hysteresis. It turns on above the upper limit and turns off below the lower limit, and register reads and shutdown leave it alone. In latched mode each qualified trip sets the alarm. The alarm then stays set until any register read or until shutdown. The trip condition alternates: the first trip needs the temperature above the upper limit, the next needs it below the lower limit, and so on. A change of mode clears a partial fault count. The limits must keep the lower limit below the upper limit; otherwise the behaviour is undefined.

Top module: `thw_alarm_ctrl`

## Requirements
- R1: Only the upper LIM_W bits (default 9) of the TEMP_W-bit (default 11) temperature are used. They are compared as signed two's-complement values against the signed limits, so the discarded low bits never affect the outcome.
- R2: A result is evaluated only on a cycle where `conv_done` is high and `cfg_shutdown` is low. A conversion strobe during shutdown has no effect.
- R3: In thermostat mode (`cfg_latch_mode`=0), an inactive alarm becomes active once the queued number of consecutive evaluated results are strictly greater than `limit_hi`.
- R4: In thermostat mode, an active alarm becomes inactive once the queued number of consecutive evaluated results are strictly less than `limit_lo`. Register reads and shutdown do not change the alarm in this mode.
- R5: In latched mode (`cfg_latch_mode`=1), the first activation after reset needs results above `limit_hi`. Once it has been cleared, the next activation needs results below `limit_lo`, and the trip condition alternates after every activation.
- R6: In latched mode, an active alarm stays active through further conversions. It is cleared in the cycle after a `reg_read` pulse or while `cfg_shutdown` is high.
- R7: `cfg_queue` sets the number of consecutive qualifying results needed: 00 needs 1, 01 needs 2, 10 needs 4, 11 needs 6. Any evaluated result that fails the current trip condition restarts the count.
- R8: `cfg_pol_high`=0 makes `alarm_level` low while the alarm is active and high while it is inactive. `cfg_pol_high`=1 inverts this. The level follows the polarity bit with no delay.
- R9: After reset the alarm is inactive (`alarm_level` high at default polarity), the fault count is zero, and the latched-mode trip condition is the upper limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_done | input | 1 | One-cycle strobe: a new temperature result is valid |
| temp_code | input | 11 | Temperature result, two's complement, 0.125 degree steps |
| limit_hi | input | 9 | Upper trip limit, two's complement, 0.5 degree steps |
| limit_lo | input | 9 | Lower release limit, two's complement, 0.5 degree steps |
| cfg_shutdown | input | 1 | Shutdown: ignore conversions, clear a latched alarm |
| cfg_latch_mode | input | 1 | 0 thermostat mode, 1 latched mode |
| cfg_pol_high | input | 1 | 1 selects an active-high alarm level |
| cfg_queue | input | 2 | Fault queue code |
| reg_read | input | 1 | One-cycle pulse: a register was read |
| alarm_level | output | 1 | Alarm level before open-drain conversion |

## Verification
The hardest state to reach is the second half of the latched cycle. The alarm must already have tripped on the upper limit and been cleared by a read. Only then does a hot result have to be ignored while a cold one sets the alarm. The stimulus builds this history step by step: a hot trip, a read, a further hot result, a cold trip, a shutdown clear, and a final hot trip. Fault-queue depths are tested with runs of hot results broken by a cold one, so that a counter which did not restart would fire early. Results that differ only in the two discarded bits, negative limits, and negative temperatures test the signed truncation.

// File: rtl/thw_pkg.sv
package thw_pkg;
   localparam int QUEUE_MAX = 6;
   localparam int CNT_W     = $clog2(QUEUE_MAX + 1);

   function automatic logic [CNT_W-1:0] queue_target(input logic [1:0] code);
      case (code)
         2'b00:   return CNT_W'(1);
         2'b01:   return CNT_W'(2);
         2'b10:   return CNT_W'(4);
         default: return CNT_W'(6);
      endcase
   endfunction
endpackage

// File: rtl/thw_trip_cmp.sv
module thw_trip_cmp #(
   parameter int TEMP_W = 11,
   parameter int LIM_W  = 9
) (
   input  logic [TEMP_W-1:0] temp_code,
   input  logic [LIM_W-1:0]  limit_hi,
   input  logic [LIM_W-1:0]  limit_lo,
   output logic              above_hi,
   output logic              below_lo
);
   logic signed [LIM_W-1:0] t_cmp;

   generate
      if (TEMP_W < LIM_W) begin : g_bad
         $error("thw_trip_cmp: TEMP_W must not be below LIM_W");
      end else if (TEMP_W == LIM_W) begin : g_same
         assign t_cmp = temp_code;
      end else begin : g_trunc
         localparam int DROP = TEMP_W - LIM_W;
         logic unused_lsb;
         assign t_cmp      = temp_code[TEMP_W-1 -: LIM_W];
         assign unused_lsb = ^temp_code[DROP-1:0];
      end
   endgenerate

   assign above_hi = t_cmp > $signed(limit_hi);
   assign below_lo = t_cmp < $signed(limit_lo);
endmodule

// File: rtl/thw_fault_filter.sv
module thw_fault_filter
   import thw_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic             trip,
   input  logic [CNT_W-1:0] target,
   output logic             fire
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_inc;

   assign cnt_inc = cnt + CNT_W'(1);
   assign fire    = step && trip && !clr && (cnt_inc >= target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (clr)              cnt <= '0;
      else if (step) begin
         if (!trip || fire)      cnt <= '0;
         else                    cnt <= cnt_inc;
      end
   end

   AST_NOTRIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !trip) |=> (cnt == '0)); // R7
   AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CNT_W'(QUEUE_MAX)); // R7
endmodule

// File: rtl/thw_alarm_state.sv
module thw_alarm_state (
   input  logic clk,
   input  logic rst_n,
   input  logic conv_done,
   input  logic shutdown,
   input  logic latch_mode,
   input  logic reg_read,
   input  logic above_hi,
   input  logic below_lo,
   input  logic fire,
   output logic step,
   output logic trip,
   output logic clr_cnt,
   output logic active
);
   logic armed_hi;
   logic mode_q;

   assign step    = conv_done && !shutdown && !(latch_mode && active);
   assign trip    = latch_mode ? (armed_hi ? above_hi : below_lo)
                               : (active   ? below_lo : above_hi);
   assign clr_cnt = latch_mode != mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         armed_hi <= 1'b1;
         mode_q   <= 1'b0;
      end else begin
         mode_q <= latch_mode;
         if (latch_mode) begin
            if (shutdown || reg_read) begin
               active <= 1'b0;
            end else if (fire) begin
               active   <= 1'b1;
               armed_hi <= !armed_hi;
            end
         end else if (fire) begin
            active <= !active;
         end
      end
   end

   AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch_mode && !conv_done) |=> $stable(active)); // R4
   AST_LATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_mode && (reg_read || shutdown)) |=> !active); // R6
   AST_RISE_NEEDS_CONV: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> $past(conv_done && !shutdown)); // R2
   AST_ARM_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(armed_hi) |-> $rose(active)); // R5
endmodule

// File: rtl/thw_alarm_ctrl.sv
module thw_alarm_ctrl
   import thw_pkg::*;
#(
   parameter int TEMP_W = 11,
   parameter int LIM_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_done,
   input  logic [TEMP_W-1:0] temp_code,
   input  logic [LIM_W-1:0]  limit_hi,
   input  logic [LIM_W-1:0]  limit_lo,
   input  logic              cfg_shutdown,
   input  logic              cfg_latch_mode,
   input  logic              cfg_pol_high,
   input  logic [1:0]        cfg_queue,
   input  logic              reg_read,
   output logic              alarm_level
);
   logic above_hi, below_lo;
   logic step, trip, fire, clr_cnt, active;

   thw_trip_cmp #(.TEMP_W(TEMP_W), .LIM_W(LIM_W)) u_cmp (
      .temp_code (temp_code),
      .limit_hi  (limit_hi),
      .limit_lo  (limit_lo),
      .above_hi  (above_hi),
      .below_lo  (below_lo)
   );

   thw_fault_filter u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr_cnt),
      .step   (step),
      .trip   (trip),
      .target (queue_target(cfg_queue)),
      .fire   (fire)
   );

   thw_alarm_state u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .conv_done  (conv_done),
      .shutdown   (cfg_shutdown),
      .latch_mode (cfg_latch_mode),
      .reg_read   (reg_read),
      .above_hi   (above_hi),
      .below_lo   (below_lo),
      .fire       (fire),
      .step       (step),
      .trip       (trip),
      .clr_cnt    (clr_cnt),
      .active     (active)
   );

   assign alarm_level = cfg_pol_high ? active : !active;

   AST_POL_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_level == cfg_pol_high) |-> active); // R8
endmodule

// File: tb/tb_thw_alarm_ctrl.sv
module tb_thw_alarm_ctrl;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_done = 1'b0;
   logic [10:0] temp_code = '0;
   logic [8:0]  limit_hi = 9'd160;
   logic [8:0]  limit_lo = 9'd150;
   logic        cfg_shutdown = 1'b0;
   logic        cfg_latch_mode = 1'b0;
   logic        cfg_pol_high = 1'b0;
   logic [1:0]  cfg_queue = 2'b00;
   logic        reg_read = 1'b0;
   logic        alarm_level;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   thw_alarm_ctrl dut (
      .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .temp_code(temp_code),
      .limit_hi(limit_hi), .limit_lo(limit_lo), .cfg_shutdown(cfg_shutdown),
      .cfg_latch_mode(cfg_latch_mode), .cfg_pol_high(cfg_pol_high),
      .cfg_queue(cfg_queue), .reg_read(reg_read), .alarm_level(alarm_level)
   );

   // row: {conv, temp[10:0], read, shutdown, expected level}; thermostat, queue 1, active low
   localparam logic [14:0] VEC [0:8] = '{
      {1'b1, 11'd600,  1'b0, 1'b0, 1'b1},  // R1 150 not above 160
      {1'b1, 11'd642,  1'b0, 1'b0, 1'b1},  // R1 low bits dropped: 160
      {1'b1, 11'd644,  1'b0, 1'b0, 1'b0},  // R3 161 trips
      {1'b0, 11'd0,    1'b1, 1'b0, 1'b0},  // R4 read ignored
      {1'b0, 11'd0,    1'b0, 1'b1, 1'b0},  // R4 shutdown ignored
      {1'b1, 11'd400,  1'b0, 1'b1, 1'b0},  // R2 conversion in shutdown ignored
      {1'b1, 11'd600,  1'b0, 1'b0, 1'b0},  // R4 150 not below 150
      {1'b1, 11'd596,  1'b0, 1'b0, 1'b1},  // R4 149 releases
      {1'b1, 11'h7F8,  1'b0, 1'b0, 1'b1}   // R1 negative, no trip
   };

   task automatic chk(input logic exp, input string tag);
      checks++;
      if (alarm_level !== exp) begin
         errors++;
         $display("FAIL %s: alarm_level=%0b expected=%0b", tag, alarm_level, exp);
      end
   endtask

   task automatic drive(input logic c, input logic [10:0] t, input logic r);
      conv_done = c;
      temp_code = t;
      reg_read  = r;
      @(negedge clk);
      conv_done = 1'b0;
      reg_read  = 1'b0;
   endtask

   task automatic do_reset(input logic mode, input logic [1:0] q);
      rst_n = 1'b0;
      cfg_shutdown = 1'b0;
      cfg_pol_high = 1'b0;
      cfg_latch_mode = mode;
      cfg_queue = q;
      limit_hi = 9'd160;
      limit_lo = 9'd150;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      do_reset(1'b0, 2'b00);
      chk(1'b1, "R9 reset level");

      for (int i = 0; i < 9; i++) begin
         cfg_shutdown = VEC[i][1];
         drive(VEC[i][14], VEC[i][13:3], VEC[i][2]);
         chk(VEC[i][0], $sformatf("R1/R2/R3/R4 vector %0d", i));
      end
      cfg_shutdown = 1'b0;

      // R7 queue 2, both directions
      do_reset(1'b0, 2'b01);
      drive(1'b1, 11'd700, 1'b0); chk(1'b1, "R7 q2 one hot");
      drive(1'b1, 11'd700, 1'b0); chk(1'b0, "R7 q2 two hot");
      drive(1'b1, 11'd500, 1'b0); chk(1'b0, "R7 q2 one cold");
      drive(1'b1, 11'd500, 1'b0); chk(1'b1, "R7 q2 two cold");

      // R7 queue 4 with a broken run
      do_reset(1'b0, 2'b10);
      drive(1'b1, 11'd700, 1'b0);
      drive(1'b1, 11'd700, 1'b0);
      drive(1'b1, 11'd500, 1'b0);
      drive(1'b1, 11'd700, 1'b0);
      drive(1'b1, 11'd700, 1'b0);
      drive(1'b1, 11'd700, 1'b0); chk(1'b1, "R7 q4 three after break");
      drive(1'b1, 11'd700, 1'b0); chk(1'b0, "R7 q4 fourth");

      // R7 queue 6
      do_reset(1'b0, 2'b11);
      for (int k = 0; k < 5; k++) drive(1'b1, 11'd700, 1'b0);
      chk(1'b1, "R7 q6 five hot");
      drive(1'b1, 11'd700, 1'b0); chk(1'b0, "R7 q6 sixth");

      // R1 signed limits and temperatures
      do_reset(1'b0, 2'b00);
      limit_hi = 9'h1EC;   // -20
      limit_lo = 9'h1D8;   // -40
      drive(1'b1, 11'h7D8, 1'b0); chk(1'b0, "R1 R3 -10 above -20");
      drive(1'b1, 11'h790, 1'b0); chk(1'b0, "R1 R4 -28 not below -40");
      drive(1'b1, 11'h700, 1'b0); chk(1'b1, "R1 R4 -64 below -40");

      // R5 R6 latched mode
      do_reset(1'b1, 2'b00);
      chk(1'b1, "R9 latched reset");
      drive(1'b1, 11'd700, 1'b0); chk(1'b0, "R5 first trip hot");
      drive(1'b1, 11'd500, 1'b0); chk(1'b0, "R6 holds through conversion");
      drive(1'b0, 11'd0, 1'b1);   chk(1'b1, "R6 read clears");
      drive(1'b1, 11'd700, 1'b0); chk(1'b1, "R5 hot ignored after clear");
      drive(1'b1, 11'd500, 1'b0); chk(1'b0, "R5 cold trips");
      cfg_shutdown = 1'b1;
      drive(1'b0, 11'd0, 1'b0);   chk(1'b1, "R6 shutdown clears");
      cfg_shutdown = 1'b0;
      drive(1'b1, 11'd500, 1'b0); chk(1'b1, "R5 cold ignored, hot armed");
      drive(1'b1, 11'd700, 1'b0); chk(1'b0, "R5 hot trips again");
      drive(1'b0, 11'd0, 1'b1);   chk(1'b1, "R6 read clears again");

      // R8 polarity
      cfg_pol_high = 1'b1;
      #1; chk(1'b0, "R8 inactive high polarity");
      drive(1'b1, 11'd500, 1'b0); chk(1'b1, "R8 active high polarity");
      cfg_pol_high = 1'b0;
      #1; chk(1'b0, "R8 active low polarity");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule